// File: doc/BRIEF.md
# Ring Buffer Burst Splitter

This block turns one request for N quadwords (16 bytes each) that starts inside a power-of-two ring buffer into one or two linear bursts of 32-bit word addresses. The ring is described by a base address and a mask equal to the ring size in bytes minus 16. When the requested span reaches past the top of the ring, the block first emits the words up to the ring end. It then emits the remaining words from the ring base.

The number of quadwords moved is the smaller of the requester's remaining count and the count of valid quadwords the ring currently holds. Word addresses leave on a valid/ready port. A stall input ends the current request at once. The block then reports how many whole quadwords were consumed, the word offset inside the partly sent quadword, and the wrapped address to continue from. A later request marked as a resume skips that stored offset. When a request finishes, a done pulse carries the consumed count, which the parent subtracts from its count of valid ring data.

Top module: `ring_burst_splitter`

## Requirements
- R1: On done, `done_addr` equals base + ((start + done_qwc*16) AND mask), where start is the request address. For a rejected request it equals the request address.
- R2: A request moves min(`req_qwc`, `ring_qwc`) quadwords. That is 4 words per quadword, less the resume offset, when no stall occurs.
- R3: When start + count*16 does not exceed the ring end (base + mask + 16), the words form one burst. The burst starts at the start address plus 4*offset, each later address is 4 higher, and `out_part` is 0 throughout.
- R4: When the span exceeds the ring end, part 0 carries (end - start)/4 words (less the offset) up to the ring end. Part 1 then carries the remaining words from the ring base, with `out_part` = 1.
- R5: While `stall` is high, `out_valid` is 0. A stall during a burst ends the request with `done_stalled` = 1, and no later word of either part is issued.
- R6: On done, `done_qwc` = (offset + words sent)/4 rounded down, and `done_off` = (offset + words sent) mod 4.
- R7: A request with `req_resume` = 1 uses the `done_off` of the last accepted non-rejected request as its offset. Its first word is at start + 4*offset.
- R8: A request is rejected if any of these holds: mask bits [3:0] are not zero; mask+16 is not a power of two; the base is not aligned to the ring size; the address is not 16-byte aligned; or the address lies outside the ring. A rejected request issues no words and gives done with `done_err` = 1, `done_qwc` = 0 and `done_off` = 0.
- R9: `req_ready` is high only when the block is idle. `out_addr` holds its value while `out_valid` is high and `out_ready` is low.
- R10: `done` is a single-cycle pulse, one per accepted request, in the cycle after the last word handshake or the stall. `out_last` marks the final word of each part.
- R11: A request whose quadword count is zero issues no words and gives done with `done_qwc` = 0 and `done_stalled` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | AW | Ring base byte address |
| cfg_mask | input | AW | Ring size in bytes minus 16 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | AW | Start byte address inside the ring |
| req_qwc | input | QW | Quadwords the requester still needs |
| ring_qwc | input | QW | Valid quadwords held in the ring |
| req_resume | input | 1 | Apply the stored word offset |
| stall | input | 1 | Stop the running request |
| out_valid | output | 1 | Word address valid |
| out_ready | input | 1 | Sink accepts the word |
| out_addr | output | AW | Byte address of the word |
| out_part | output | 1 | 0 for the first burst, 1 for the wrapped burst |
| out_last | output | 1 | Final word of the current part |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 1 | Request was rejected |
| done_stalled | output | 1 | Request ended by a stall |
| done_qwc | output | QW | Whole quadwords consumed |
| done_addr | output | AW | Wrapped address to continue from |
| done_off | output | 2 | Word offset inside the next quadword |

## Verification
Requests that stay below the ring end are checked against requests that end exactly on it and against requests that cross it. This separates the one-burst path from the split and shows that an end-aligned span is not split. Cases where the ring count limits the request, set against cases where the requester's count does, show which side of the minimum is taken. Stalls are placed in the first part, in the second part and before any word. Each stall is followed by a resume, so the skipped offset and the reported address can be told apart from a fresh start. Rejected configurations and addresses, a zero count and a larger ring run with a sink that is always ready and with one that holds back every third cycle.

// File: rtl/ring_burst_pkg.sv
package ring_burst_pkg;

    localparam int QW_SHIFT   = 4;
    localparam int WORD_SHIFT = 2;
    localparam int WORD_BYTES = 1 << WORD_SHIFT;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HEAD = 2'd1,
        SEQ_TAIL = 2'd2,
        SEQ_FIN  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/rbs_cfg_check.sv
module rbs_cfg_check
    import ring_burst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    output logic          bad
);
    localparam int LOWW = QW_SHIFT;

    logic [AW-1:0] low_ones;
    logic [AW:0]   size_w;
    logic [AW:0]   size_m1;
    logic          mask_low_bad;
    logic          size_bad;
    logic          base_bad;
    logic          addr_bad;

    always_comb begin
        low_ones     = mask | {{(AW-LOWW){1'b0}}, {LOWW{1'b1}}};
        size_w       = {1'b0, mask} + (AW+1)'(1 << QW_SHIFT);
        size_m1      = {1'b0, low_ones};
        mask_low_bad = (mask[LOWW-1:0] != '0);
        size_bad     = ((size_w & size_m1) != '0);
        base_bad     = ((base & low_ones) != '0);
        addr_bad     = (addr[LOWW-1:0] != '0) || ((addr & ~low_ones) != base);
        bad          = mask_low_bad || size_bad || base_bad || addr_bad;
    end
endmodule

// File: rtl/rbs_split_calc.sv
module rbs_split_calc
    import ring_burst_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   mask,
    input  logic [AW-1:0]   addr,
    input  logic [QW-1:0]   req_qwc,
    input  logic [QW-1:0]   ring_qwc,
    input  logic [1:0]      off,
    output logic [AW-1:0]   p1_addr,
    output logic [QW+1:0]   p1_words,
    output logic [QW+1:0]   p2_words
);
    logic [QW-1:0] qwc_eff;
    logic [QW-1:0] head_q;
    logic [AW-1:0] ring_end;
    logic [AW-1:0] span_q;

    always_comb begin
        qwc_eff  = (req_qwc < ring_qwc) ? req_qwc : ring_qwc;
        ring_end = base + mask + AW'(1 << QW_SHIFT);
        span_q   = (ring_end - addr) >> QW_SHIFT;
        if ({{(AW-QW){1'b0}}, qwc_eff} > span_q) begin
            head_q = span_q[QW-1:0];
        end else begin
            head_q = qwc_eff;
        end
        if (qwc_eff == '0) begin
            p1_words = '0;
        end else begin
            p1_words = ({2'b00, head_q} << 2) - {{QW{1'b0}}, off};
        end
        p2_words = {2'b00, qwc_eff - head_q} << 2;
        p1_addr  = addr + {{(AW-4){1'b0}}, off, 2'b00};
    end
endmodule

// File: rtl/rbs_burst_seq.sv
module rbs_burst_seq
    import ring_burst_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_err,
    input  logic [AW-1:0] p1_addr,
    input  logic [QW+1:0] p1_words,
    input  logic [QW+1:0] p2_words,
    input  logic [AW-1:0] ring_base,
    input  logic          stall,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic          out_part,
    output logic          out_last,
    output logic          fin,
    output logic          fin_err,
    output logic          fin_stalled,
    output logic [QW+1:0] sent_words,
    output logic          idle
);
    seq_state_e    state_q;
    logic [AW-1:0] addr_q;
    logic [QW+1:0] left_q;
    logic [QW+1:0] tail_q;
    logic [QW+1:0] sent_q;
    logic          err_q;
    logic          stl_q;
    logic          bursting;
    logic          part_end;

    assign bursting = (state_q == SEQ_HEAD) || (state_q == SEQ_TAIL);
    assign part_end = (left_q == (QW+2)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            tail_q  <= '0;
            sent_q  <= '0;
            err_q   <= 1'b0;
            stl_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        sent_q <= '0;
                        stl_q  <= 1'b0;
                        err_q  <= start_err;
                        addr_q <= p1_addr;
                        left_q <= p1_words;
                        tail_q <= p2_words;
                        if (start_err || (p1_words == '0)) begin
                            state_q <= SEQ_FIN;
                        end else begin
                            state_q <= SEQ_HEAD;
                        end
                    end
                end
                SEQ_HEAD, SEQ_TAIL: begin
                    if (stall) begin
                        stl_q   <= 1'b1;
                        state_q <= SEQ_FIN;
                    end else if (out_ready) begin
                        sent_q <= sent_q + (QW+2)'(1);
                        if (part_end) begin
                            if ((state_q == SEQ_HEAD) && (tail_q != '0)) begin
                                state_q <= SEQ_TAIL;
                                addr_q  <= ring_base;
                                left_q  <= tail_q;
                            end else begin
                                state_q <= SEQ_FIN;
                            end
                        end else begin
                            addr_q <= addr_q + AW'(WORD_BYTES);
                            left_q <= left_q - (QW+2)'(1);
                        end
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign out_valid   = bursting && !stall;
    assign out_addr    = addr_q;
    assign out_part    = (state_q == SEQ_TAIL);
    assign out_last    = bursting && part_end;
    assign fin         = (state_q == SEQ_FIN);
    assign fin_err     = err_q;
    assign fin_stalled = stl_q;
    assign sent_words  = sent_q;
    assign idle        = (state_q == SEQ_IDLE);
endmodule

// File: rtl/ring_burst_splitter.sv
module ring_burst_splitter
    import ring_burst_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_mask,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [QW-1:0] req_qwc,
    input  logic [QW-1:0] ring_qwc,
    input  logic          req_resume,
    input  logic          stall,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_part,
    output logic          out_last,
    output logic          done,
    output logic          done_err,
    output logic          done_stalled,
    output logic [QW-1:0] done_qwc,
    output logic [AW-1:0] done_addr,
    output logic [1:0]    done_off
);
    typedef struct packed {
        logic [AW-1:0] start;
        logic [1:0]    off;
    } req_ctx_t;

    req_ctx_t      ctx_q;
    logic [1:0]    off_store_q;
    logic [1:0]    off_use;
    logic          accept;
    logic          cfg_bad;
    logic          seq_idle;
    logic [AW-1:0] p1_addr;
    logic [QW+1:0] p1_words;
    logic [QW+1:0] p2_words;
    logic [QW+1:0] sent_words;
    logic [QW+1:0] sum_words;
    logic [AW-1:0] advance;
    logic          fin;
    logic          fin_err;
    logic          fin_stalled;

    assign off_use   = req_resume ? off_store_q : 2'b00;
    assign req_ready = seq_idle;
    assign accept    = req_valid && seq_idle;

    rbs_cfg_check #(.AW(AW)) u_cfg (
        .base (cfg_base),
        .mask (cfg_mask),
        .addr (req_addr),
        .bad  (cfg_bad)
    );

    rbs_split_calc #(.AW(AW), .QW(QW)) u_split (
        .base     (cfg_base),
        .mask     (cfg_mask),
        .addr     (req_addr),
        .req_qwc  (req_qwc),
        .ring_qwc (ring_qwc),
        .off      (off_use),
        .p1_addr  (p1_addr),
        .p1_words (p1_words),
        .p2_words (p2_words)
    );

    rbs_burst_seq #(.AW(AW), .QW(QW)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_err   (cfg_bad),
        .p1_addr     (p1_addr),
        .p1_words    (p1_words),
        .p2_words    (p2_words),
        .ring_base   (cfg_base),
        .stall       (stall),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_part    (out_part),
        .out_last    (out_last),
        .fin         (fin),
        .fin_err     (fin_err),
        .fin_stalled (fin_stalled),
        .sent_words  (sent_words),
        .idle        (seq_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q       <= '0;
            off_store_q <= 2'b00;
        end else begin
            if (accept) begin
                ctx_q.start <= req_addr;
                ctx_q.off   <= off_use;
            end
            if (fin && !fin_err) begin
                off_store_q <= sum_words[1:0];
            end
        end
    end

    always_comb begin
        sum_words    = sent_words + {{QW{1'b0}}, ctx_q.off};
        advance      = ctx_q.start + {{(AW-QW-4){1'b0}}, sum_words[QW+1:2], 4'h0};
        done         = fin;
        done_err     = fin && fin_err;
        done_stalled = fin && fin_stalled;
        if (fin_err) begin
            done_qwc  = '0;
            done_off  = 2'b00;
            done_addr = ctx_q.start;
        end else begin
            done_qwc  = sum_words[QW+1:2];
            done_off  = sum_words[1:0];
            done_addr = cfg_base + (advance & cfg_mask);
        end
    end
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int AW = 32,
    parameter int QW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_mask,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          stall,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic          out_part,
    input logic          out_last,
    input logic          done,
    input logic          done_err
);
    logic [AW-1:0] ring_low;
    logic          req_bad;

    always_comb begin
        ring_low = cfg_mask | {{(AW-4){1'b0}}, 4'hF};
        req_bad  = (cfg_mask[3:0] != 4'h0)
                || (((cfg_mask + AW'(16)) & ring_low) != '0)
                || ((cfg_base & ring_low) != '0)
                || (req_addr[3:0] != 4'h0)
                || ((req_addr & ~ring_low) != cfg_base);
    end

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        stall |-> !out_valid); // R5

    AST_WORD_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !out_last) |=> (!out_valid || (out_addr == $past(out_addr) + AW'(4)))); // R3

    AST_TAIL_AT_BASE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && !out_part) |=> (!out_valid || (out_part && (out_addr == cfg_base)))); // R4

    AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_addr & ~ring_low) == cfg_base)); // R4

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (!out_valid || $stable(out_addr))); // R9

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_REJECT_REPORT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_bad) |=> (done && done_err && !out_valid)); // R8
endmodule

bind ring_burst_splitter rbs_checker #(.AW(AW), .QW(QW)) u_chk (.*);

// File: tb/sim_ring_burst_splitter.sv
`timescale 1ns/1ps
module sim_ring_burst_splitter;
    localparam int AW = 32;
    localparam int QW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_base = 32'h1000;
    logic [AW-1:0] cfg_mask = 32'h00F0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [QW-1:0] req_qwc = '0;
    logic [QW-1:0] ring_qwc = '0;
    logic          req_resume = 1'b0;
    logic          stall = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic          out_part;
    logic          out_last;
    logic          done;
    logic          done_err;
    logic          done_stalled;
    logic [QW-1:0] done_qwc;
    logic [AW-1:0] done_addr;
    logic [1:0]    done_off;

    ring_burst_splitter #(.AW(AW), .QW(QW)) u0 (.*);

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit active = 0;
    int rdy_mode = 0;
    int cyc = 0;

    longint exp_addr_q[$];
    bit     exp_part_q[$];
    bit     exp_last_q[$];
    string  exp_tag_q[$];
    int     sent = 0;
    int     model_off = 0;
    longint cur_start = 0;
    int     cur_off = 0;
    int     cur_total = 0;
    bit     cur_err = 0;
    int     done_cnt = 0;
    bit     done_seen = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit cfg_bad(input longint b, input longint m, input longint a);
        longint sz;
        sz = m + 16;
        return (m % 16 != 0) || ((sz & (sz - 1)) != 0) || (b % sz != 0)
            || (a % 16 != 0) || (a < b) || (a >= b + sz);
    endfunction

    // ready pattern driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        end
    end

    // cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (active && !rst) begin
            if (stall) chk(out_valid == 1'b0, "R5", "valid during stall", out_valid, 0);
            if (out_valid) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected word", out_addr, 0);
                end else begin
                    chk(out_addr == exp_addr_q[0], exp_tag_q[0], "word address", out_addr, exp_addr_q[0]);
                    chk(out_part == exp_part_q[0], "R4", "part flag", out_part, exp_part_q[0]);
                    chk(out_last == exp_last_q[0], "R10", "last flag", out_last, exp_last_q[0]);
                    if (out_ready) begin
                        void'(exp_addr_q.pop_front());
                        void'(exp_part_q.pop_front());
                        void'(exp_last_q.pop_front());
                        void'(exp_tag_q.pop_front());
                        sent++;
                    end
                end
            end
            if (done) begin
                longint eq, ea, sz;
                int eo;
                bit es;
                done_cnt++;
                done_seen = 1;
                sz = longint'(cfg_mask) + 16;
                eq = cur_err ? 0 : (cur_off + sent) / 4;
                eo = cur_err ? 0 : (cur_off + sent) % 4;
                es = !cur_err && (sent < cur_total);
                ea = cur_err ? cur_start
                             : longint'(cfg_base) + ((cur_start - longint'(cfg_base) + eq * 16) % sz);
                chk(done_err == cur_err, "R8", "done_err", done_err, cur_err);
                chk(done_qwc == QW'(eq), "R6", "done_qwc", done_qwc, eq);
                chk(done_off == 2'(eo), "R6", "done_off", done_off, eo);
                chk(done_addr == AW'(ea), "R1", "done_addr", done_addr, ea);
                chk(done_stalled == es, "R5", "done_stalled", done_stalled, es);
                if (!cur_err) model_off = eo;
            end
        end
    end

    task automatic do_req(input longint addr, input int qreq, input int qring,
                          input bit resume, input int stall_at, input string tag);
        int q;
        longint rend, sz, a;
        q = (qreq < qring) ? qreq : qring;
        sz = longint'(cfg_mask) + 16;
        rend = longint'(cfg_base) + sz;
        cur_err = cfg_bad(longint'(cfg_base), longint'(cfg_mask), addr);
        cur_off = resume ? model_off : 0;
        cur_start = addr;
        sent = 0;
        done_cnt = 0;
        done_seen = 0;
        exp_addr_q.delete(); exp_part_q.delete(); exp_last_q.delete(); exp_tag_q.delete();
        cur_total = (cur_err || q == 0) ? 0 : q * 4 - cur_off;
        if (!cur_err) begin
            for (int w = cur_off; w < q * 4; w++) begin
                a = addr + w * 4;
                exp_part_q.push_back(a >= rend);
                exp_last_q.push_back((w == q * 4 - 1) || (a + 4 == rend));
                if (a >= rend) a = a - sz;
                exp_addr_q.push_back(a);
                exp_tag_q.push_back((w == cur_off && cur_off != 0) ? "R7" : tag);
            end
        end
        chk(req_ready == 1'b1, "R9", "ready when idle", req_ready, 1);
        req_addr = AW'(addr);
        req_qwc = QW'(qreq);
        ring_qwc = QW'(qring);
        req_resume = resume;
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_resume = 1'b0;
        forever begin
            if (stall_at >= 0 && sent >= stall_at) stall = 1'b1;
            if (done_seen || finished) break;
            @(posedge clk);
            #1;
        end
        stall = 1'b0;
        chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
        if (stall_at < 0) chk(exp_addr_q.size() == 0, "R2", "words left unsent", exp_addr_q.size(), 0);
        else if (!cur_err) chk(sent == stall_at, "R5", "words before stall", sent, stall_at);
        @(posedge clk);
        #1;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
        chk(out_valid == 1'b0, "R10", "reset valid", out_valid, 0);
        chk(done == 1'b0, "R10", "reset done", done, 0);
        @(posedge clk);
        #1;
        active = 1;

        for (int pass = 0; pass < 2; pass++) begin
            rdy_mode = pass;
            cfg_base = 32'h1000;
            cfg_mask = 32'h00F0;
            do_req(32'h1000, 3, 10, 0, -1, "R3");    // single burst
            do_req(32'h1020, 8, 2, 0, -1, "R2");     // ring count limits
            do_req(32'h10E0, 4, 16, 0, -1, "R4");    // split 8+8
            do_req(32'h10E0, 2, 16, 0, -1, "R3");    // ends exactly at ring end
            do_req(32'h10C0, 6, 16, 0, 5, "R5");     // stall in part 0
            do_req(32'h10D0, 5, 16, 1, -1, "R7");    // resume, then split
            do_req(32'h10F0, 3, 16, 0, 6, "R5");     // stall in part 1
            do_req(32'h1000, 2, 16, 1, -1, "R7");    // resume offset 2
            do_req(32'h1040, 0, 16, 0, -1, "R11");   // zero count from requester
            do_req(32'h1040, 5, 0, 0, -1, "R11");    // empty ring
            do_req(32'h1080, 2, 16, 0, 0, "R5");     // stall before any word
            cfg_mask = 32'h01F0;
            do_req(32'h11F0, 2, 32, 0, -1, "R4");    // larger ring split
            cfg_mask = 32'h00F8;
            do_req(32'h1000, 2, 16, 0, -1, "R8");    // mask low bits set
            cfg_mask = 32'h0170;
            do_req(32'h1000, 2, 16, 0, -1, "R8");    // size not power of two
            cfg_mask = 32'h00F0;
            cfg_base = 32'h1010;
            do_req(32'h1010, 2, 16, 0, -1, "R8");    // base misaligned
            cfg_base = 32'h1000;
            do_req(32'h2000, 2, 16, 0, -1, "R8");    // address outside ring
            do_req(32'h1004, 2, 16, 0, -1, "R8");    // address unaligned
        end
        summary();
    end
endmodule